// File: doc/BRIEF.md
# Four-Target Two-Bank Interrupt Router

This block gathers 64 interrupt request lines, grouped as a 32-bit legacy bank and a 32-bit extended bank, and delivers them to four processors: three application cores and one service core. Every target keeps its own copy of the pending flags for both banks. It also has its own enable mask for each bank. A request therefore becomes pending for all four targets at once, and each target acknowledges it separately.

Sources are sampled on the clock, and only a low-to-high transition counts as a request. Software reaches the registers over a plain 32-bit register port. Writes are single-cycle, and read data is combinational from the address. A pending flag is cleared by writing a one to its bit position. Each target has one registered interrupt line. That line is high whenever an enabled pending flag exists in either bank.

Top module: `irq_router`

## Requirements
- R1: After reset every pending flag, mask and spare register reads zero and all four interrupt outputs are low.
- R2: A rising edge on a source line makes the matching pending bit 1 in the same bank for all four targets, at the first clock edge that sees the line high.
- R3: A source held high after its edge does not set its pending bit again once software clears it.
- R4: Writing a word to a target's pending register clears exactly the bits written as 1. Bits written as 0 keep their value. The other targets' pending registers are not affected.
- R5: If a source edge and a clearing write to the same bit fall in the same cycle, the bit ends up 1.
- R6: Mask registers read back exactly the value last written.
- R7: irq_out[t] is 1 exactly when, at the previous clock edge, some bit of target t was both pending and enabled in either bank. It reacts one cycle after a flag or mask change.
- R8: Target t (0 to 2 for the application cores, 3 for the service core, output bit t) has its registers at byte address 0x10*t. The offsets within that block are: legacy pending at +0x0, extended pending at +0x4, legacy mask at +0x8 and extended mask at +0xC.
- R9: Addresses 0x40 (legacy) and 0x44 (extended) hold spare read/write words for the service core. Their contents never affect any output.
- R10: An address above 0x44, or one whose two low bits are nonzero, reads zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lo | input | 32 | Legacy-bank request lines |
| src_hi | input | 32 | Extended-bank request lines |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | 4 | Interrupt line per target |

## Verification
The properties assume the register port issues at most one write per cycle. They also assume the write address stays stable while bus_we is high. Request lines are taken as synchronous to clk, so that an edge means one sampled transition. The stimulus changes addresses, strobes and request lines only just after a rising edge, holding each for whole cycles, and it creates same-cycle collisions between an edge and a clear on purpose. Misaligned and out-of-range addresses are driven only as complete single-cycle accesses.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  src_lo,
  input  logic [W-1:0]  src_hi,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [3:0]    irq_out
);
  localparam int NT = 4;
  localparam logic [AW-1:0] SPARE_LO = AW'(8'h40);
  localparam logic [AW-1:0] SPARE_HI = AW'(8'h44);

  logic [W-1:0] st_lo [NT];
  logic [W-1:0] st_hi [NT];
  logic [W-1:0] mk_lo [NT];
  logic [W-1:0] mk_hi [NT];
  logic [W-1:0] spare_lo, spare_hi;
  logic [W-1:0] src_lo_q, src_hi_q;
  logic [3:0]   irq_q;

  wire [W-1:0] rise_lo = src_lo & ~src_lo_q;
  wire [W-1:0] rise_hi = src_hi & ~src_hi_q;
  wire         aligned = (bus_addr[1:0] == 2'b00);
  wire         in_tgt  = aligned && (bus_addr[AW-1:6] == '0);
  wire [1:0]   tsel    = bus_addr[5:4];
  wire [1:0]   rsel    = bus_addr[3:2];

  assign irq_out = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_lo_q <= '0;
      src_hi_q <= '0;
      spare_lo <= '0;
      spare_hi <= '0;
      irq_q    <= '0;
      for (int i = 0; i < NT; i++) begin
        st_lo[i] <= '0;
        st_hi[i] <= '0;
        mk_lo[i] <= '0;
        mk_hi[i] <= '0;
      end
    end else begin
      src_lo_q <= src_lo;
      src_hi_q <= src_hi;
      for (int i = 0; i < NT; i++) begin
        logic wr_t;
        wr_t = bus_we && in_tgt && (tsel == 2'(i));
        st_lo[i] <= (st_lo[i] & ~((wr_t && rsel == 2'd0) ? bus_wdata : '0)) | rise_lo;
        st_hi[i] <= (st_hi[i] & ~((wr_t && rsel == 2'd1) ? bus_wdata : '0)) | rise_hi;
        if (wr_t && rsel == 2'd2) mk_lo[i] <= bus_wdata;
        if (wr_t && rsel == 2'd3) mk_hi[i] <= bus_wdata;
        irq_q[i] <= |((st_lo[i] & mk_lo[i]) | (st_hi[i] & mk_hi[i]));
      end
      if (bus_we && bus_addr == SPARE_LO) spare_lo <= bus_wdata;
      if (bus_we && bus_addr == SPARE_HI) spare_hi <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_tgt) begin
      case (rsel)
        2'd0: bus_rdata = st_lo[tsel];
        2'd1: bus_rdata = st_hi[tsel];
        2'd2: bus_rdata = mk_lo[tsel];
        default: bus_rdata = mk_hi[tsel];
      endcase
    end else if (bus_addr == SPARE_LO) begin
      bus_rdata = spare_lo;
    end else if (bus_addr == SPARE_HI) begin
      bus_rdata = spare_hi;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> irq_out == 4'b0000);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > AW'(8'h44) || bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);

  generate
    for (genvar t = 0; t < NT; t++) begin : g_chk
      localparam logic [AW-1:0] BASE = AW'(t * 16);

      assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_lo[t] & $past(rise_lo)) == $past(rise_lo)) &&
                 ((st_hi[t] & $past(rise_hi)) == $past(rise_hi)));

      assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == BASE && rise_lo == '0) |=> (st_lo[t] & $past(bus_wdata)) == '0);

      assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == BASE) |=> (st_lo[t] & $past(st_lo[t])) == $past(st_lo[t]));

      assert_mask_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == BASE + AW'(8)) |=> mk_lo[t] == $past(bus_wdata));

      assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out[t] == $past(|((st_lo[t] & mk_lo[t]) | (st_hi[t] & mk_hi[t]))));
    end
  endgenerate
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int CLK_NS = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src_lo = '0, src_hi = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_out;

  int total = 0, bad = 0;
  bit done = 0;
  bit mon_en = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  irq_router uut (.clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_hi(src_hi),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (mon_en && sb.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sb.pop_front();
      got = it.is_irq ? {28'd0, irq_out} : bus_rdata;
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    mon_en = 1;
    @(posedge clk); #1;
    mon_en = 0;
  endtask

  task automatic irq_now(input logic [3:0] e, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {28'd0, e}; it.tag = tag;
    sb.push_back(it);
    mon_en = 1;
    @(posedge clk); #1;
    mon_en = 0;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string tag);
    @(posedge clk); #1;
    irq_now(e, tag);
  endtask

  task automatic pulse_lo(input logic [31:0] b);
    @(posedge clk); #1; src_lo = src_lo | b;
    @(posedge clk); #1; src_lo = src_lo & ~b;
  endtask

  task automatic pulse_hi(input logic [31:0] b);
    @(posedge clk); #1; src_hi = src_hi | b;
    @(posedge clk); #1; src_hi = src_hi & ~b;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++)
        rd(8'(t*16 + r*4), 32'h0, "R1 register after reset");
    rd(8'h40, 32'h0, "R1 spare lo after reset");
    chk_irq(4'b0000, "R1 outputs after reset");

    // R6 mask read back, R8 map
    wr(8'h08, 32'h0000_0005);
    wr(8'h3C, 32'h8000_0000);
    rd(8'h08, 32'h0000_0005, "R6 core0 legacy mask");
    rd(8'h3C, 32'h8000_0000, "R6 R8 service extended mask");
    rd(8'h18, 32'h0, "R8 core1 legacy mask untouched");

    // R2 broadcast, R7 output
    pulse_lo(32'h1);
    for (int t = 0; t < 4; t++) rd(8'(t*16), 32'h1, "R2 legacy flag in every target");
    chk_irq(4'b0001, "R7 core0 enabled flag");

    // R4 clear only one target
    wr(8'h00, 32'h1);
    rd(8'h00, 32'h0, "R4 core0 cleared");
    rd(8'h10, 32'h1, "R4 core1 untouched");
    chk_irq(4'b0000, "R7 core0 drops after clear");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h1, "R4 zero write keeps bit");

    // R2 extended bank, R7 service output
    pulse_hi(32'h8000_0000);
    for (int t = 0; t < 4; t++) rd(8'(t*16 + 4), 32'h8000_0000, "R2 extended flag in every target");
    chk_irq(4'b1000, "R7 service extended");
    wr(8'h34, 32'h8000_0000);
    chk_irq(4'b0000, "R7 service drops after clear");

    // R3 held source
    @(posedge clk); #1 src_lo = src_lo | 32'h10;
    rd(8'h20, 32'h11, "R3 held source sets once");
    wr(8'h20, 32'h10);
    repeat (3) @(posedge clk);
    rd(8'h20, 32'h01, "R3 held source does not re-set");

    // R5 set wins
    pulse_lo(32'h80);
    rd(8'h10, 32'h91, "R5 precondition");
    @(posedge clk); #1;
    src_lo = src_lo | 32'h80; bus_addr = 8'h10; bus_we = 1; bus_wdata = 32'h80;
    @(posedge clk); #1;
    bus_we = 0; src_lo = src_lo & ~32'h80;
    rd(8'h10, 32'h91, "R5 edge beats clear");

    // R7 one-cycle latency on mask change
    wr(8'h18, 32'h80);
    irq_now(4'b0000, "R7 not yet after mask write");
    chk_irq(4'b0010, "R7 asserted one cycle later");

    // R9 spare words
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, 32'hFFFF_FFFF, "R9 spare lo read back");
    rd(8'h44, 32'hFFFF_FFFF, "R9 spare hi read back");
    chk_irq(4'b0010, "R9 spare has no effect on outputs");

    // R10 unmapped
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h48, 32'h0, "R10 above range reads zero");
    rd(8'h80, 32'h0, "R10 far address reads zero");
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h02, 32'h0, "R10 misaligned reads zero");
    rd(8'h00, 32'h90, "R10 misaligned write ignored");
    wr(8'h0A, 32'h0);
    rd(8'h08, 32'h5, "R10 misaligned mask write ignored");

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule